// File: doc/BRIEF.md
# Layered Write-Protection Controller for a 256-Byte Nonvolatile Array

This block keeps the protection state of a byte-addressed nonvolatile array and rules on every write that tries to reach it. Two software flags guard the lower half of the array. One flag can never be cleared once it is set. The other can be set and cleared again. A hardware protect pin overrides both flags and guards the whole array. The serial bus engine hands the block each control byte as fields that are already decoded: a 4-bit control code, three select bits and the read/write bit. Along with these it passes the logic levels of the three address pins and a single-bit qualifier that reports a high voltage on address pin 0.

One cycle after each control byte, the block gives an acknowledge decision. For commands on the protection code, that decision is also the only way the flag status is reported. When a flag command is accepted as a write, the block raises a program request. The flag changes only when the write-cycle sequencer pulses the commit strobe. For any byte address the bus engine presents, a combinational write-allowed output tells the engine whether the store may go ahead. A blocked array write is still acknowledged by the bus engine; only the store is dropped.

Top module: `eeprom_guard`

## Requirements
- R1: While `wp_pin` is 1, `wr_allow` is 0 for every address, whatever the state of the flags.
- R2: While `wp_pin` is 0 and either flag is set, `wr_allow` is 0 for addresses 00h to 7Fh and 1 for addresses 80h to FFh. With both flags clear, every address is writable.
- R3: A control byte with code 0110, select bits equal to the pin levels and rw=0 (and no reversible pattern) is acknowledged while the permanent flag is clear. It raises `prog_req`, and the next `commit` sets the permanent flag.
- R4: Once the permanent flag is set, it never clears, and every control byte with code 0110 is answered with ack=0.
- R5: Reversible set is code 0110, select 001, `a0_hv`=1 and pin levels A2=A1=0. It is acknowledged and raises `prog_req` only while the reversible flag is clear; otherwise ack=0.
- R6: Reversible clear is code 0110, select 011, `a0_hv`=1, pin A2=0 and pin A1=1, with rw=0. It is acknowledged while the permanent flag is clear, and the next `commit` clears the reversible flag.
- R7: A status query is the matching byte with rw=1. On the reversible patterns, ack=1 means the reversible flag is clear. On the permanent pattern, ack=1 means the permanent flag is clear. A query never raises `prog_req`.
- R8: A flag command that arrives while `wp_pin` is 1 gets the same ack as with the pin low, but raises no `prog_req` and changes no flag.
- R9: Code 1010 is acknowledged when the select bits equal the pin levels, for either rw and whatever the flags. Any code other than 1010 or 0110 gets ack=0. Neither of these raises `prog_req`.
- R10: `ack_vld` and `ack` reflect the byte presented with `cmd_valid` exactly one cycle later. A flag changes only on the cycle after a `commit` with a request pending, and `prog_req` drops then.
- R11: A 0110 byte whose select bits form a reversible pattern but which arrives with `a0_hv`=0 follows the permanent-flag rules.
- R12: After reset, the flags hold their preload values (both clear by default), and `ack_vld` and `prog_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the flag preloads |
| cmd_valid | input | 1 | One-cycle strobe: a control byte is presented |
| cmd_code | input | 4 | Control code nibble of the byte |
| cmd_sel | input | 3 | Select bits of the byte (A2 A1 A0 order) |
| cmd_rw | input | 1 | 1 = read/query, 0 = write |
| pin_lvl | input | 3 | Logic levels of address pins A2 A1 A0 |
| a0_hv | input | 1 | High voltage present on address pin 0 |
| wp_pin | input | 1 | Hardware protect pin, 1 = protect all |
| commit | input | 1 | Write-cycle sequencer commit strobe |
| wr_addr | input | 8 | Byte address being judged |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| prog_req | output | 1 | A flag program operation is pending |
| wr_allow | output | 1 | Write to `wr_addr` may proceed |

## Verification
The hardest state to reach is a set permanent flag sitting next to a reversible flag that has been set and then cleared. This matters because the permanent flag cannot be undone, so every reversible-flag scenario has to run earlier in one ordered pass. The stimulus works through the reversible set, query, clear and protect-pin-blocked cases first. It reaches the permanent flag last, through a reversible-looking byte sent without the high-voltage qualifier. It then tests that every 0110 byte is refused and that the lower half stays blocked. A behavioural model updated on every edge is compared against all four outputs on every cycle.

// File: rtl/guard_pkg.sv
package guard_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_SET_P = 2'd1,
      OP_SET_R = 2'd2,
      OP_CLR_R = 2'd3
   } guard_op_e;

   typedef struct packed {
      logic      ack;
      guard_op_e op;
   } guard_resp_t;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
   import guard_pkg::*;
#(
   parameter int         SEL_W      = 3,
   parameter logic [3:0] CODE_ARRAY = 4'b1010,
   parameter logic [3:0] CODE_PROT  = 4'b0110
) (
   input  logic [3:0]       code,
   input  logic [SEL_W-1:0] sel,
   input  logic             rw,
   input  logic [SEL_W-1:0] pins,
   input  logic             hv,
   input  logic             wp,
   input  logic             perm_set,
   input  logic             rev_set,
   output guard_resp_t      resp
);
   localparam logic [SEL_W-1:0] SEL_RSET = SEL_W'(3'b001);
   localparam logic [SEL_W-1:0] SEL_RCLR = SEL_W'(3'b011);

   logic is_array, is_prot, sel_match;
   logic pat_rset, pat_rclr, pat_perm;

   always_comb begin
      is_array  = (code == CODE_ARRAY);
      is_prot   = (code == CODE_PROT);
      sel_match = (sel == pins);
      pat_rset  = hv && (sel == SEL_RSET) && (pins[SEL_W-1:1] == '0);
      pat_rclr  = hv && (sel == SEL_RCLR) && (pins[SEL_W-1:1] == (SEL_W-1)'(1));
      pat_perm  = !pat_rset && !pat_rclr && sel_match;
   end

   always_comb begin
      resp.ack = 1'b0;
      resp.op  = OP_NONE;
      if (is_array) begin
         resp.ack = sel_match;
      end else if (is_prot && !perm_set) begin
         if (pat_rset) begin
            resp.ack = !rev_set;
            if (!rw && !rev_set && !wp) resp.op = OP_SET_R;
         end else if (pat_rclr) begin
            resp.ack = rw ? !rev_set : 1'b1;
            if (!rw && !wp) resp.op = OP_CLR_R;
         end else if (pat_perm) begin
            resp.ack = 1'b1;
            if (!rw && !wp) resp.op = OP_SET_P;
         end
      end
   end
endmodule

// File: rtl/guard_flags.sv
module guard_flags
   import guard_pkg::*;
#(
   parameter bit PERM_INIT = 1'b0,
   parameter bit REV_INIT  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  guard_resp_t resp,
   input  logic        commit,
   output logic        perm_q,
   output logic        rev_q,
   output logic        ack_vld,
   output logic        ack,
   output logic        prog_req
);
   guard_op_e pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perm_q  <= PERM_INIT;
         rev_q   <= REV_INIT;
         pend_q  <= OP_NONE;
         ack_vld <= 1'b0;
         ack     <= 1'b0;
      end else begin
         ack_vld <= cmd_valid;
         ack     <= cmd_valid && resp.ack;
         if (commit) begin
            unique case (pend_q)
               OP_SET_P: perm_q <= 1'b1;
               OP_SET_R: rev_q  <= 1'b1;
               OP_CLR_R: rev_q  <= 1'b0;
               default:  ;
            endcase
            pend_q <= OP_NONE;
         end
         if (cmd_valid && resp.op != OP_NONE) pend_q <= resp.op;
      end
   end

   assign prog_req = (pend_q != OP_NONE);
endmodule

// File: rtl/guard_window.sv
module guard_window #(
   parameter int ADDR_W     = 8,
   parameter int PROT_LIMIT = 128
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wp,
   input  logic              soft_on,
   output logic              allow
);
   localparam bool_pow2 = (PROT_LIMIT & (PROT_LIMIT - 1)) == 0;
   localparam int  LOW_W = $clog2(PROT_LIMIT);
   logic in_low;

   generate
      if (bool_pow2 && LOW_W < ADDR_W) begin : g_mask
         assign in_low = (addr[ADDR_W-1:LOW_W] == '0);
      end else begin : g_cmp
         assign in_low = ({1'b0, addr} < (ADDR_W+1)'(PROT_LIMIT));
      end
   endgenerate

   assign allow = !wp && !(soft_on && in_low);
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
   import guard_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         SEL_W      = 3,
   parameter int         PROT_LIMIT = 2 ** (ADDR_W - 1),
   parameter logic [3:0] CODE_ARRAY = 4'b1010,
   parameter logic [3:0] CODE_PROT  = 4'b0110,
   parameter bit         PERM_INIT  = 1'b0,
   parameter bit         REV_INIT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_code,
   input  logic [SEL_W-1:0]  cmd_sel,
   input  logic              cmd_rw,
   input  logic [SEL_W-1:0]  pin_lvl,
   input  logic              a0_hv,
   input  logic              wp_pin,
   input  logic              commit,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              ack_vld,
   output logic              ack,
   output logic              prog_req,
   output logic              wr_allow
);
   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("SEL_W must be at least 2");
      end
      if (PROT_LIMIT < 1 || PROT_LIMIT > 2 ** ADDR_W) begin : g_bad_lim
         $error("PROT_LIMIT out of address range");
      end
      if (CODE_ARRAY == CODE_PROT) begin : g_bad_code
         $error("control codes must differ");
      end
   endgenerate

   guard_resp_t resp;
   logic        perm_q, rev_q;

   guard_decode #(
      .SEL_W(SEL_W), .CODE_ARRAY(CODE_ARRAY), .CODE_PROT(CODE_PROT)
   ) u_dec (
      .code(cmd_code), .sel(cmd_sel), .rw(cmd_rw), .pins(pin_lvl),
      .hv(a0_hv), .wp(wp_pin), .perm_set(perm_q), .rev_set(rev_q),
      .resp(resp)
   );

   guard_flags #(.PERM_INIT(PERM_INIT), .REV_INIT(REV_INIT)) u_flags (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .resp(resp),
      .commit(commit), .perm_q(perm_q), .rev_q(rev_q),
      .ack_vld(ack_vld), .ack(ack), .prog_req(prog_req)
   );

   guard_window #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_win (
      .addr(wr_addr), .wp(wp_pin), .soft_on(perm_q || rev_q),
      .allow(wr_allow)
   );
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
   parameter int         ADDR_W     = 8,
   parameter int         PROT_LIMIT = 128,
   parameter logic [3:0] CODE_PROT  = 4'b0110
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [3:0]        cmd_code,
   input logic              wp_pin,
   input logic              commit,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              ack_vld,
   input logic              ack,
   input logic              prog_req,
   input logic              wr_allow,
   input logic              perm_q,
   input logic              rev_q
);
   AST_WP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      wp_pin |-> !wr_allow);                                         // R1
   AST_LOW_HALF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((perm_q || rev_q) && ({1'b0, wr_addr} < (ADDR_W+1)'(PROT_LIMIT))) |-> !wr_allow); // R2
   AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(perm_q) |-> perm_q);                                     // R4
   AST_PERM_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == CODE_PROT && perm_q) |=> (ack_vld && !ack)); // R4
   AST_WP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && wp_pin && !prog_req) |=> !prog_req);             // R8
   AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit) |-> ($stable(perm_q) && $stable(rev_q)));       // R10
   AST_ACK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ack_vld);                                              // R10
endmodule

bind eeprom_guard guard_chk #(
   .ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT), .CODE_PROT(CODE_PROT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .wp_pin(wp_pin), .commit(commit), .wr_addr(wr_addr), .ack_vld(ack_vld),
   .ack(ack), .prog_req(prog_req), .wr_allow(wr_allow),
   .perm_q(perm_q), .rev_q(rev_q)
);

// File: tb/sim_eeprom_guard.sv
`timescale 1ns/1ps
module sim_eeprom_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [3:0] cmd_code = 4'h0;
   logic [2:0] cmd_sel = 3'b000;
   logic       cmd_rw = 1'b0;
   logic [2:0] pin_lvl = 3'b000;
   logic       a0_hv = 1'b0;
   logic       wp_pin = 1'b0;
   logic       commit = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic       ack_vld, ack, prog_req, wr_allow;

   always #5 clk = ~clk;

   eeprom_guard u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_sel(cmd_sel), .cmd_rw(cmd_rw), .pin_lvl(pin_lvl), .a0_hv(a0_hv),
      .wp_pin(wp_pin), .commit(commit), .wr_addr(wr_addr),
      .ack_vld(ack_vld), .ack(ack), .prog_req(prog_req), .wr_allow(wr_allow)
   );

   // behavioural reference: 0 none, 1 set perm, 2 set rev, 3 clear rev
   int    m_perm = 0, m_rev = 0, m_pend = 0, m_vld = 0, m_ack = 0;
   int    checks = 0, failures = 0, cycles = 0;
   string tag = "R12";
   bit    done = 1'b0;

   function automatic int judge(output int op);
      int a = 0;
      op = 0;
      if (cmd_code == 4'b1010) a = (cmd_sel == pin_lvl);
      else if (cmd_code == 4'b0110 && m_perm == 0) begin
         if (a0_hv && cmd_sel == 3'b001 && pin_lvl[2:1] == 2'b00) begin
            a = (m_rev == 0);
            if (!cmd_rw && a == 1) op = 2;
         end else if (a0_hv && cmd_sel == 3'b011 && pin_lvl[2:1] == 2'b01) begin
            a = cmd_rw ? (m_rev == 0) : 1;
            if (!cmd_rw) op = 3;
         end else if (cmd_sel == pin_lvl) begin
            a = 1;
            if (!cmd_rw) op = 1;
         end
         if (wp_pin) op = 0;
      end
      return a;
   endfunction

   always @(posedge clk) begin
      int a, op;
      if (!rst_n) begin
         m_perm = 0; m_rev = 0; m_pend = 0; m_vld = 0; m_ack = 0;
      end else begin
         a = judge(op);
         if (commit) begin
            if (m_pend == 1) m_perm = 1;
            if (m_pend == 2) m_rev = 1;
            if (m_pend == 3) m_rev = 0;
            m_pend = 0;
         end
         if (cmd_valid && op != 0) m_pend = op;
         m_vld = cmd_valid;
         m_ack = cmd_valid ? a : 0;
      end
   end

   task automatic cmp(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int allow_m;
      if (rst_n && !done) begin
         allow_m = (!wp_pin && !((m_perm || m_rev) && wr_addr < 8'h80)) ? 1 : 0;
         cmp("ack_vld", ack_vld, m_vld);
         cmp("ack", ack, m_ack);
         cmp("prog_req", prog_req, (m_pend != 0) ? 1 : 0);
         cmp("wr_allow", wr_allow, allow_m);
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic send(input logic [3:0] c, input logic [2:0] s, input logic rw,
                       input logic [2:0] p, input logic hv);
      cmd_code = c; cmd_sel = s; cmd_rw = rw; pin_lvl = p; a0_hv = hv;
      cmd_valid = 1'b1;
      step();
      cmd_valid = 1'b0;
      step();
   endtask

   task automatic do_commit();
      commit = 1'b1;
      step();
      commit = 1'b0;
      step();
   endtask

   task automatic sweep();
      for (int k = 0; k < 256; k += 17) begin
         wr_addr = 8'(k);
         step();
      end
      wr_addr = 8'h7F; step();
      wr_addr = 8'h80; step();
   endtask

   // explicit expectation checks beyond the lockstep model
   task automatic expect_out(input string what, input int act, input int exp);
      cmp(what, act, exp);
   endtask

   initial begin
      step(3);
      // R12: reset state held during reset
      expect_out("reset ack_vld", ack_vld, 0);
      expect_out("reset prog_req", prog_req, 0);
      rst_n = 1'b1;
      step(2);
      tag = "R2";  sweep();
      tag = "R9";
      send(4'b1010, 3'b000, 1'b0, 3'b000, 1'b0);
      send(4'b1010, 3'b101, 1'b1, 3'b101, 1'b0);
      send(4'b1010, 3'b001, 1'b0, 3'b000, 1'b0);
      send(4'b1111, 3'b000, 1'b0, 3'b000, 1'b0);
      tag = "R7";  send(4'b0110, 3'b010, 1'b1, 3'b010, 1'b0);
      tag = "R5";
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1);
      expect_out("R5 req raised", prog_req, 1);
      tag = "R10"; wr_addr = 8'h10; step(3);
      expect_out("R10 no change before commit", wr_allow, 1);
      do_commit();
      tag = "R2";  sweep();
      tag = "R5";  send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1);
      tag = "R7";  send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b1);
      send(4'b0110, 3'b000, 1'b1, 3'b000, 1'b0);
      tag = "R6";
      send(4'b0110, 3'b011, 1'b0, 3'b011, 1'b1);
      do_commit();
      wr_addr = 8'h05; step();
      expect_out("R6 cleared", wr_allow, 1);
      tag = "R8";
      wp_pin = 1'b1;
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1);
      send(4'b0110, 3'b000, 1'b0, 3'b000, 1'b0);
      do_commit();
      tag = "R1";  sweep();
      wp_pin = 1'b0;
      tag = "R8";  wr_addr = 8'h05; step();
      expect_out("R8 flags untouched", wr_allow, 1);
      tag = "R11";
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b0);
      tag = "R3";
      send(4'b1010, 3'b000, 1'b0, 3'b000, 1'b0);
      do_commit();
      wr_addr = 8'h05; step();
      expect_out("R3 low half locked", wr_allow, 0);
      tag = "R4";
      send(4'b0110, 3'b001, 1'b1, 3'b001, 1'b0);
      send(4'b0110, 3'b001, 1'b0, 3'b001, 1'b1);
      send(4'b0110, 3'b011, 1'b0, 3'b011, 1'b1);
      do_commit();
      send(4'b0110, 3'b000, 1'b0, 3'b000, 1'b0);
      tag = "R2";  sweep();
      tag = "R9";  send(4'b1010, 3'b000, 1'b0, 3'b000, 1'b0);
      tag = "R1";  wp_pin = 1'b1; sweep(); wp_pin = 1'b0;
      step(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule